// File: doc/BRIEF.md
# Completion Timeout and Tag Tracker

This block keeps track of non-posted read requests that an endpoint has sent and not yet seen answered. Each accepted request takes the lowest-numbered free tag from a fixed pool and is remembered together with its requester ID and a private wait counter. A returning completion is matched against the live entries on the pair (requester ID, tag). A match retires the entry. A completion that finds no live entry raises an unexpected-completion pulse. A request that waits past its limit raises a completion-timeout pulse and gives its tag back to the pool.

The wait limit is taken from a 4-bit range code on a control input. Four codes select four terminal counts that are set by parameters. Any other code, zero included, selects a default count. The limit is captured when the request is accepted, so a change of code affects only later requests. When programmability is turned off by parameter, the capability output reads zero and every request uses the default count. Because a tag freed by timeout can be handed to a new request, a completion that arrives late is reported as unexpected and never retires the wrong request. Both error pulses carry the tag involved and feed an error-reporting block.

Top module: `cpl_tag_tracker`

## Requirements
- R1: A synchronous reset frees every entry and raises no error pulse. After reset, `req_ready` is 1, `req_tag` is 0, and `cto_pulse` and `uc_pulse` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. It takes the tag shown on `req_tag`, which is the lowest-numbered free tag. `req_ready` is 0 while all NUM_TAGS entries are live.
- R3: A completion with `cpl_valid` 1 whose (`cpl_rid`, `cpl_tag`) equals a live entry frees that entry at the same edge. It raises no error, and the tag can be allocated again from the next edge onward.
- R4: A completion that matches no live entry raises `uc_pulse` for one cycle after its edge, with `uc_tag` equal to `cpl_tag`. This covers a free tag and also a live tag held with a different requester ID. A live entry whose requester ID differs is left untouched.
- R5: A request accepted at edge A that stays unanswered raises `cto_pulse`, with `cto_tag` equal to its tag, in the cycle after edge A+TC+1. TC is the terminal count captured at acceptance. The entry is freed at that same edge.
- R6: With programmability on, range code 1 selects TC_A, 2 selects TC_B, 3 selects TC_C and 4 selects TC_D. Code 0 and every other code select TC_DEF. The defaults are 8, 16, 32, 64 and 20 cycles.
- R7: With programmability off (PROG_EN = 0), `cap_ranges` reads 4'b0000 and every request uses TC_DEF whatever the range code. With it on, `cap_ranges` reads 4'b1111, where bit i means code i+1 is supported.
- R8: The terminal count is captured when the request is accepted. Changing `ctl_range` later does not change when an outstanding request times out.
- R9: If a matching completion arrives at the same edge where its entry would time out, the completion wins. No `cto_pulse` and no `uc_pulse` follow.
- R10: A completion that arrives after its request has timed out is reported as unexpected. The same holds after the tag has been reused by a new request with a different requester ID, and in that case the new request stays live.
- R11: When several entries are due in the same cycle, one timeout is reported per cycle, lowest tag first. The others are reported in the following cycles, and none is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_range | input | 4 | Timeout range code applied to newly accepted requests |
| cap_ranges | output | 4 | Supported range codes, bit i for code i+1; zero when not programmable |
| req_valid | input | 1 | A non-posted request is offered |
| req_rid | input | RID_W | Requester ID of the offered request |
| req_ready | output | 1 | A tag is free, so the request can be accepted |
| req_tag | output | TAG_W | Tag that the offered request receives |
| cpl_valid | input | 1 | A completion is presented |
| cpl_rid | input | RID_W | Requester ID carried by the completion |
| cpl_tag | input | TAG_W | Tag carried by the completion |
| cto_pulse | output | 1 | One-cycle completion-timeout error |
| cto_tag | output | TAG_W | Tag of the request that timed out |
| uc_pulse | output | 1 | One-cycle unexpected-completion error |
| uc_tag | output | TAG_W | Tag carried by the unexpected completion |

## Verification
The bench targets the edge where a completion and an expiry coincide. A design that let the timer win would report a timeout for a request that was answered, or would flag the completion as unexpected. It also covers a late completion after the tag has been reused under another requester ID: a design that matched on tag alone would retire the new request silently. Two entries are made to expire in the same cycle, which catches a design that drops the second timeout. A range-code change while a request is in flight catches a design that reads the live code instead of the captured count, and a full pool checks back-pressure and lowest-free reuse.

// File: rtl/cpl_trk_pkg.sv
package cpl_trk_pkg;

   // Range codes understood on the control input; any other code selects the default count
   typedef enum logic [3:0] {
      RNG_NONE = 4'd0,
      RNG_A    = 4'd1,
      RNG_B    = 4'd2,
      RNG_C    = 4'd3,
      RNG_D    = 4'd4
   } rng_code_e;

   localparam int NUM_RANGES = 4;

endpackage

// File: rtl/cto_limit_sel.sv
module cto_limit_sel
   import cpl_trk_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit PROG_EN = 1'b1,
   parameter int TC_A    = 8,
   parameter int TC_B    = 16,
   parameter int TC_C    = 32,
   parameter int TC_D    = 64,
   parameter int TC_DEF  = 20
) (
   input  logic [3:0]       ctl_range,
   output logic [CNT_W-1:0] limit,
   output logic [3:0]       cap_ranges
);

   localparam longint CNT_SPAN = longint'(1) << CNT_W;

   if (TC_A < 1 || TC_B < 1 || TC_C < 1 || TC_D < 1 || TC_DEF < 1) begin : g_bad_zero
      $error("cto_limit_sel: terminal counts must be at least 1");
   end
   if (longint'(TC_A) >= CNT_SPAN || longint'(TC_B) >= CNT_SPAN ||
       longint'(TC_C) >= CNT_SPAN || longint'(TC_D) >= CNT_SPAN ||
       longint'(TC_DEF) >= CNT_SPAN) begin : g_bad_width
      $error("cto_limit_sel: CNT_W too narrow for a terminal count");
   end

   if (PROG_EN) begin : g_prog
      always_comb begin
         case (rng_code_e'(ctl_range))
            RNG_A:   limit = CNT_W'(TC_A);
            RNG_B:   limit = CNT_W'(TC_B);
            RNG_C:   limit = CNT_W'(TC_C);
            RNG_D:   limit = CNT_W'(TC_D);
            default: limit = CNT_W'(TC_DEF);
         endcase
      end
      assign cap_ranges = 4'((1 << NUM_RANGES) - 1);
   end else begin : g_fixed
      logic unused_ctl;
      assign unused_ctl = ^ctl_range;
      assign limit      = CNT_W'(TC_DEF);
      assign cap_ranges = 4'b0000;
   end

endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   if (N < 1 || N > (1 << IDX_W)) begin : g_bad_n
      $error("lowest_pick: N does not fit IDX_W");
   end

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/tag_slot.sv
module tag_slot #(
   parameter int RID_W = 16,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             alloc,
   input  logic [RID_W-1:0] alloc_rid,
   input  logic [CNT_W-1:0] alloc_lim,
   input  logic             clear,
   output logic             vld,
   output logic [RID_W-1:0] rid,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld <= 1'b0;
         rid <= '0;
         cnt <= '0;
         lim <= '0;
      end else if (clear) begin
         vld <= 1'b0;
      end else if (alloc) begin
         vld <= 1'b1;
         rid <= alloc_rid;
         cnt <= '0;
         lim <= alloc_lim;
      end else if (vld && cnt < lim) begin
         cnt <= cnt + 1'b1;
      end
   end

   // waiting entry holds at its limit until the timeout is granted
   assign expired = vld && (cnt >= lim);

   // R5
   cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
      vld |-> cnt <= lim);

   // R2
   no_double_use_chk: assert property (@(posedge clk) disable iff (rst)
      alloc |-> !vld);

   // R8
   lim_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (vld && $past(vld) && !$past(alloc)) |-> $stable(lim));

endmodule

// File: rtl/cpl_tag_tracker.sv
module cpl_tag_tracker
   import cpl_trk_pkg::*;
#(
   parameter int NUM_TAGS = 8,
   parameter int RID_W    = 16,
   parameter int CNT_W    = 16,
   parameter bit PROG_EN  = 1'b1,
   parameter int TC_A     = 8,
   parameter int TC_B     = 16,
   parameter int TC_C     = 32,
   parameter int TC_D     = 64,
   parameter int TC_DEF   = 20,
   localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [3:0]       ctl_range,
   output logic [3:0]       cap_ranges,
   input  logic             req_valid,
   input  logic [RID_W-1:0] req_rid,
   output logic             req_ready,
   output logic [TAG_W-1:0] req_tag,
   input  logic             cpl_valid,
   input  logic [RID_W-1:0] cpl_rid,
   input  logic [TAG_W-1:0] cpl_tag,
   output logic             cto_pulse,
   output logic [TAG_W-1:0] cto_tag,
   output logic             uc_pulse,
   output logic [TAG_W-1:0] uc_tag
);

   if (NUM_TAGS < 1 || NUM_TAGS > 256) begin : g_bad_tags
      $error("cpl_tag_tracker: NUM_TAGS out of range");
   end
   if (RID_W < 1) begin : g_bad_rid
      $error("cpl_tag_tracker: RID_W must be positive");
   end

   logic [NUM_TAGS-1:0] vld;
   logic [NUM_TAGS-1:0] exp_vec;
   logic [NUM_TAGS-1:0] hit_vec;
   logic [NUM_TAGS-1:0] alloc_vec;
   logic [NUM_TAGS-1:0] clr_vec;
   logic [RID_W-1:0]    slot_rid [NUM_TAGS];
   logic [CNT_W-1:0]    sel_lim;
   logic                accept;
   logic                cpl_hit;
   logic                cto_any;
   logic [TAG_W-1:0]    cto_idx;

   cto_limit_sel #(
      .CNT_W  (CNT_W),
      .PROG_EN(PROG_EN),
      .TC_A   (TC_A),
      .TC_B   (TC_B),
      .TC_C   (TC_C),
      .TC_D   (TC_D),
      .TC_DEF (TC_DEF)
   ) u_lim (
      .ctl_range (ctl_range),
      .limit     (sel_lim),
      .cap_ranges(cap_ranges)
   );

   // free-tag allocator: lowest free entry
   lowest_pick #(.N(NUM_TAGS), .IDX_W(TAG_W)) u_alloc (
      .req(~vld),
      .any(req_ready),
      .idx(req_tag)
   );

   // timeout arbiter: lowest due entry not being answered this cycle
   lowest_pick #(.N(NUM_TAGS), .IDX_W(TAG_W)) u_cto (
      .req(exp_vec & ~hit_vec),
      .any(cto_any),
      .idx(cto_idx)
   );

   assign accept  = req_valid && req_ready;
   assign cpl_hit = |hit_vec;

   for (genvar t = 0; t < NUM_TAGS; t++) begin : g_slot
      tag_slot #(.RID_W(RID_W), .CNT_W(CNT_W)) u_slot (
         .clk      (clk),
         .rst      (rst),
         .alloc    (alloc_vec[t]),
         .alloc_rid(req_rid),
         .alloc_lim(sel_lim),
         .clear    (clr_vec[t]),
         .vld      (vld[t]),
         .rid      (slot_rid[t]),
         .expired  (exp_vec[t])
      );

      assign hit_vec[t]   = cpl_valid && vld[t] && (cpl_tag == TAG_W'(t)) &&
                            (slot_rid[t] == cpl_rid);
      assign alloc_vec[t] = accept && (req_tag == TAG_W'(t));
      assign clr_vec[t]   = hit_vec[t] || (cto_any && (cto_idx == TAG_W'(t)));

      // R5
      cto_was_live_chk: assert property (@(posedge clk) disable iff (rst)
         (cto_pulse && cto_tag == TAG_W'(t)) |-> ($past(vld[t]) && !vld[t]));

      // R9
      hit_no_cto_chk: assert property (@(posedge clk) disable iff (rst)
         hit_vec[t] |=> !(cto_pulse && cto_tag == TAG_W'(t)));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cto_pulse <= 1'b0;
         cto_tag   <= '0;
         uc_pulse  <= 1'b0;
         uc_tag    <= '0;
      end else begin
         cto_pulse <= cto_any;
         cto_tag   <= cto_idx;
         uc_pulse  <= cpl_valid && !cpl_hit;
         uc_tag    <= cpl_tag;
      end
   end

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (!cto_pulse && !uc_pulse && vld == '0));

   // R2
   alloc_live_chk: assert property (@(posedge clk) disable iff (rst)
      accept |=> vld[$past(req_tag)]);

   // R4
   uc_from_cpl_chk: assert property (@(posedge clk) disable iff (rst)
      uc_pulse |-> $past(cpl_valid));

   // R3
   hit_no_uc_chk: assert property (@(posedge clk) disable iff (rst)
      cpl_hit |=> !uc_pulse);

   // R11
   one_grant_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(clr_vec & ~hit_vec) <= 1);

endmodule

// File: tb/cpl_tag_tracker_tb.sv
module cpl_tag_tracker_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NT         = 8;
   localparam int TC_DEF     = 20;

   typedef struct {
      int cyc;
      int tag;
   } ev_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  ctl = 4'd0;
   logic        req_valid = 1'b0;
   logic [15:0] req_rid = '0;
   logic        cpl_valid = 1'b0;
   logic [15:0] cpl_rid = '0;
   logic [2:0]  cpl_tag = '0;

   logic [3:0]  cap_ranges, fx_cap;
   logic        req_ready, fx_ready;
   logic [2:0]  req_tag, fx_req_tag;
   logic        cto_pulse, fx_cto, uc_pulse, fx_uc;
   logic [2:0]  cto_tag, fx_cto_tag, uc_tag, fx_uc_tag;

   int  cyc = 0;
   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   ev_t exp_cto[$];
   ev_t exp_uc[$];
   bit          busy [NT];
   int          busy_until [NT];
   logic [15:0] rid_m [NT];

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cpl_tag_tracker u_dut (
      .clk(clk), .rst(rst), .ctl_range(ctl), .cap_ranges(cap_ranges),
      .req_valid(req_valid), .req_rid(req_rid), .req_ready(req_ready), .req_tag(req_tag),
      .cpl_valid(cpl_valid), .cpl_rid(cpl_rid), .cpl_tag(cpl_tag),
      .cto_pulse(cto_pulse), .cto_tag(cto_tag), .uc_pulse(uc_pulse), .uc_tag(uc_tag)
   );

   cpl_tag_tracker #(.PROG_EN(1'b0)) u_fix (
      .clk(clk), .rst(rst), .ctl_range(ctl), .cap_ranges(fx_cap),
      .req_valid(req_valid), .req_rid(req_rid), .req_ready(fx_ready), .req_tag(fx_req_tag),
      .cpl_valid(cpl_valid), .cpl_rid(cpl_rid), .cpl_tag(cpl_tag),
      .cto_pulse(fx_cto), .cto_tag(fx_cto_tag), .uc_pulse(fx_uc), .uc_tag(fx_uc_tag)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int tc_of(input logic [3:0] code);
      case (code)
         4'd1: return 8;
         4'd2: return 16;
         4'd3: return 32;
         4'd4: return 64;
         default: return TC_DEF;
      endcase
   endfunction

   // one timeout per cycle: a later-issued, higher tag moves to the next free cycle
   function automatic int bump(input int x);
      int y;
      bit hit;
      y = x;
      do begin
         hit = 1'b0;
         foreach (exp_cto[i]) if (exp_cto[i].cyc == y) hit = 1'b1;
         if (hit) y++;
      end while (hit);
      return y;
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic issue(input logic [15:0] rid, output int a, output int tg);
      int e;
      int t;
      int x;
      e = cyc + 1;
      t = -1;
      for (int i = NT - 1; i >= 0; i--)
         if (!(busy[i] && e <= busy_until[i])) t = i;
      // R2: lowest free tag offered
      chk(req_ready === 1'b1 && int'(req_tag) == t, "R2", "offered tag",
          req_ready ? int'(req_tag) : -1, t);
      x = bump(e + tc_of(ctl) + 1);
      exp_cto.push_back('{cyc: x, tag: t});
      busy[t]       = 1'b1;
      busy_until[t] = x;
      rid_m[t]      = rid;
      req_valid = 1'b1;
      req_rid   = rid;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      a  = e;
      tg = t;
   endtask

   task automatic complete(input logic [15:0] rid, input int tag);
      int e;
      bit live;
      e = cyc + 1;
      live = busy[tag] && e <= busy_until[tag] && rid_m[tag] == rid;
      if (live) begin
         busy[tag] = 1'b0;
         for (int i = exp_cto.size() - 1; i >= 0; i--)
            if (exp_cto[i].tag == tag) exp_cto.delete(i);
      end else begin
         exp_uc.push_back('{cyc: e, tag: tag});
      end
      cpl_valid = 1'b1;
      cpl_rid   = rid;
      cpl_tag   = 3'(tag);
      @(posedge clk);
      @(negedge clk);
      cpl_valid = 1'b0;
   endtask

   // monitor: pops expected error pulses and compares them with the outputs
   always @(negedge clk) begin
      int k;
      if (!rst && !done) begin
         k = -1;
         foreach (exp_cto[i]) if (exp_cto[i].cyc == cyc) k = i;
         if (k >= 0 || cto_pulse) begin
            // R5 R6 R8 R9 R11: timeout pulse timing and tag
            chk(k >= 0 && cto_pulse && int'(cto_tag) == exp_cto[k].tag, "R5/R9/R11",
                "cto pulse tag", cto_pulse ? int'(cto_tag) : -1, k >= 0 ? exp_cto[k].tag : -1);
            if (k >= 0) exp_cto.delete(k);
         end
         k = -1;
         foreach (exp_uc[i]) if (exp_uc[i].cyc == cyc) k = i;
         if (k >= 0 || uc_pulse) begin
            // R3 R4 R10: unexpected completion pulse
            chk(k >= 0 && uc_pulse && int'(uc_tag) == exp_uc[k].tag, "R4/R10",
                "uc pulse tag", uc_pulse ? int'(uc_tag) : -1, k >= 0 ? exp_uc[k].tag : -1);
            if (k >= 0) exp_uc.delete(k);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int a, tg, a2, tg2;
      foreach (busy[i]) begin
         busy[i] = 1'b0;
         busy_until[i] = 0;
         rid_m[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
      chk(req_tag == 3'd0, "R1", "tag after reset", req_tag, 0);
      chk(!cto_pulse && !uc_pulse, "R1", "pulses after reset", cto_pulse + uc_pulse, 0);
      // R7 capability fields
      chk(cap_ranges == 4'b1111, "R7", "cap programmable", cap_ranges, 15);
      chk(fx_cap == 4'b0000, "R7", "cap fixed", fx_cap, 0);

      // R6 code 1 on the programmable copy; R7 default count on the fixed copy
      ctl = 4'd1;
      issue(16'h0101, a, tg);
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         if (fx_cto || cyc == a + TC_DEF + 1)
            chk(fx_cto == 1'b1 && cyc == a + TC_DEF + 1, "R7", "fixed timeout cycle",
                cyc - a, TC_DEF + 1);
      end

      // R3 matched completion retires without error, tag reusable
      ctl = 4'd2;
      issue(16'h0200, a, tg);
      idle(3);
      complete(16'h0200, tg);
      chk(req_tag == 3'd0 && req_ready, "R3", "tag freed by completion", req_tag, 0);

      // R4 completion for a free tag, and for a live tag with another requester ID
      complete(16'h0333, 5);
      issue(16'h0400, a, tg);
      complete(16'h0401, tg);
      chk(req_tag == 3'd1, "R4", "mismatched rid left entry live", req_tag, 1);
      complete(16'h0400, tg);
      idle(2);

      // R2 fill the pool, back-pressure, lowest-free reuse
      ctl = 4'd4;
      for (int i = 0; i < NT; i++) issue(16'h0010 + 16'(i), a, tg);
      chk(req_ready == 1'b0, "R2", "ready when full", req_ready, 0);
      complete(rid_m[3], 3);
      chk(req_ready == 1'b1 && req_tag == 3'd3, "R2", "lowest free after retire", req_tag, 3);
      issue(16'h0777, a, tg);
      for (int i = 0; i < NT; i++) complete(rid_m[i], i);
      idle(2);

      // R8 captured count; R6 code 0 and unsupported code use the default
      ctl = 4'd3;
      issue(16'h0800, a, tg);
      ctl = 4'd0;
      issue(16'h0801, a, tg);
      ctl = 4'd9;
      issue(16'h0802, a, tg);
      ctl = 4'd1;
      idle(40);

      // R9 completion at the expiry edge wins
      issue(16'h0900, a, tg);
      idle(8);
      complete(16'h0900, tg);
      idle(4);
      chk(req_tag == 3'd0 && req_ready, "R9", "entry freed by winning completion", req_tag, 0);

      // R10 late completion after timeout, then after tag reuse
      issue(16'h0A00, a, tg);
      idle(12);
      complete(16'h0A00, tg);
      issue(16'h0B00, a, tg);
      idle(12);
      issue(16'h0B01, a2, tg2);
      chk(tg2 == tg, "R10", "timed-out tag reused", tg2, tg);
      complete(16'h0B00, tg);
      chk(req_tag == 3'd1, "R10", "reused entry still live", req_tag, 1);
      complete(16'h0B01, tg2);
      idle(2);

      // R11 two entries due in the same cycle
      ctl = 4'd2;
      issue(16'h0C00, a, tg);
      idle(7);
      ctl = 4'd1;
      issue(16'h0C01, a2, tg2);
      idle(30);

      idle(80);
      chk(exp_cto.size() == 0 && exp_uc.size() == 0, "R5/R11", "pending expected pulses",
          exp_cto.size() + exp_uc.size(), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule